// File: doc/BRIEF.md
# Link Aggregation Bucket Remapper

This block holds the table that steers hashed traffic onto the member ports of an aggregated link of up to four ports. The table is split into groups of slots, one group per port. An upstream hash picks a slot, and the entry in that slot names the egress port. When the group has more than two members, each port owns sixteen slots. With one or two members, each port owns a single slot. In the default layout, every slot of a port points back to that same port.

The block watches a transmit-enable and a link-up bit for every port. Whenever the set of usable ports changes, it rebuilds the table one slot per clock. Every slot owned by a failed port is handed, on its own, to a surviving port drawn by a pseudo-random generator. This spreads the failed port's load across the survivors, instead of moving it all to a single port. Slots of working ports always go back to their owner, so a port that recovers regains its own traffic.

The rebuilt table takes effect in one step at the end of the walk. When the rebuild is committed, the block reports which slots received a new value and how many did. A second read port gives the entry in the first slot of any port, which is that port's primary affinity.

Top module: `lag_bucket_remap`

## Requirements
- R1: During reset the member count is taken from `cfg_nports`, where 0 means 1 and any value above 4 means 4. The per-port slot count B is 16 when the member count exceeds 2 and 1 otherwise. After reset, slot p*B+j (port p counted from 0) reads p+1, every slot at or above count*B reads 0, `busy` is low and `upd_valid`, `upd_count` and `upd_mask` are all zero.
- R2: A member port is usable only when both its `tx_en` bit and its `link_up` bit are 1. Clearing either bit alone makes the port unusable.
- R3: When every member port is usable, or none is, the rebuilt table equals the default layout.
- R4: Each slot of an unusable port receives code a+1, where a is entry number (v mod N) of the ascending list of usable ports and N is the size of that list. v is the current state of a 32-bit generator. The generator is seeded with 1 at reset. Its step is s' = (s >> 1) XOR (s[0] ? 0x80200003 : 0). It steps once after each such slot, and never for any other slot. Slots are visited in ascending index order.
- R5: Every slot of a usable port holds that port's own code after a rebuild, so a recovered port gets back all of its slots.
- R6: A change in the usable-port set starts a rebuild at the next clock edge. `busy` then stays high for count*B+1 cycles. Until it falls, `lk_port` returns the table that was in force before the rebuild.
- R7: When a rebuild commits, bit i of `upd_mask` is 1 exactly when slot i took a new value, and `upd_count` is the number of such slots. Both hold until the next commit. `upd_valid` pulses for one cycle, after the commit, only if `upd_count` is nonzero.
- R8: `aff_port` returns the entry of slot `aff_sel`*B, which is 0 for a port number at or above the member count.
- R9: A status change that leaves the usable-port set unchanged starts no rebuild. This covers bits of ports at or above the member count, and moving a port between two unusable combinations of its bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_nports | input | 3 | Member port count, sampled during reset |
| tx_en | input | 4 | Per-port transmit enable |
| link_up | input | 4 | Per-port link status |
| lk_idx | input | 6 | Slot index from the packet hash |
| lk_port | output | 3 | Egress port code of the indexed slot (1-based, 0 for an unused slot) |
| aff_sel | input | 2 | Port whose primary affinity is queried |
| aff_port | output | 3 | Entry in the first slot of the queried port |
| busy | output | 1 | Rebuild in progress |
| upd_valid | output | 1 | One-cycle pulse after a commit that changed slots |
| upd_count | output | 7 | Number of slots changed by the last commit |
| upd_mask | output | 64 | Per-slot changed flags of the last commit |

## Verification
The bench builds the block with its default limits, four ports and sixteen slots per port. It resets the block in turn with member counts 4, 3, 2, 1 (from a request of 0) and 4 (from a request of 7). This puts both slot layouts within reach: sixteen slots per port with a partly filled 64-entry table, and one slot per port with a four-entry table. It also covers status bits of non-member ports, which must be ignored. For each member count, constrained-random status patterns drive rebuilds with one, two or three survivors. A bench model of the generator and of the modulo draw predicts every slot, the change mask and the walk length.

// File: rtl/lag_pkg.sv
package lag_pkg;

    localparam int MAXP        = 4;
    localparam int BKT         = 16;
    localparam int SMALL_LIMIT = 2;
    localparam int SLOTS       = MAXP * BKT;
    localparam int IW          = $clog2(SLOTS);
    localparam int PW          = $clog2(MAXP + 1);
    localparam int PSW         = $clog2(MAXP);
    localparam int CW          = $clog2(SLOTS + 1);
    localparam int BSH         = $clog2(BKT);
    localparam int RW          = 32;

    localparam logic [RW-1:0] LFSR_TAPS = 32'h8020_0003;
    localparam logic [RW-1:0] LFSR_SEED = 32'h0000_0001;

    typedef logic [PW-1:0]   port_code_t;
    typedef logic [MAXP-1:0] pmask_t;
    typedef logic [IW-1:0]   slot_idx_t;

    typedef enum logic [1:0] {
        W_IDLE,
        W_WALK,
        W_COMMIT
    } walk_st_t;

    typedef struct packed {
        slot_idx_t  idx;
        port_code_t val;
    } slot_wr_t;

    function automatic logic [RW-1:0] lfsr_step(input logic [RW-1:0] s);
        return (s >> 1) ^ (s[0] ? LFSR_TAPS : '0);
    endfunction

    function automatic port_code_t clamp_ports(input port_code_t c);
        if (c == '0) return port_code_t'(1);
        if (int'(c) > MAXP) return port_code_t'(MAXP);
        return c;
    endfunction

    function automatic int buckets_for(input port_code_t n);
        return (int'(n) > SMALL_LIMIT) ? BKT : 1;
    endfunction

    function automatic pmask_t mask_for(input port_code_t n);
        pmask_t m;
        for (int p = 0; p < MAXP; p++) m[p] = (p < int'(n));
        return m;
    endfunction

    function automatic logic [PSW-1:0] slot_owner(input slot_idx_t idx, input logic big);
        slot_idx_t sh;
        sh = idx >> BSH;
        return big ? sh[PSW-1:0] : idx[PSW-1:0];
    endfunction

    function automatic port_code_t native_entry(input int i, input port_code_t n);
        int b;
        b = buckets_for(n);
        if (i < int'(n) * b) return port_code_t'(i / b + 1);
        return '0;
    endfunction

    function automatic logic [PSW-1:0] nth_active(input pmask_t m, input int k);
        logic [PSW-1:0] res;
        int seen;
        res  = '0;
        seen = 0;
        for (int p = 0; p < MAXP; p++) begin
            if (m[p]) begin
                if (seen == k) res = PSW'(p);
                seen = seen + 1;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/lag_rand_lfsr.sv
module lag_rand_lfsr
    import lag_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [RW-1:0] rnd
);

    always_ff @(posedge clk) begin
        if (rst)      rnd <= LFSR_SEED;
        else if (adv) rnd <= lfsr_step(rnd);
    end

endmodule

// File: rtl/lag_slot_walker.sv
module lag_slot_walker
    import lag_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  pmask_t        rst_mask,
    input  pmask_t        cur_status,
    input  pmask_t        port_mask,
    input  port_code_t    nports,
    input  logic          big,
    input  logic [RW-1:0] rnd,
    output logic          adv,
    output logic          busy,
    output logic          wr_en,
    output slot_wr_t      wr,
    output logic          commit
);

    walk_st_t       state;
    slot_idx_t      idx_q;
    pmask_t         snap_q;
    int             slot_total;
    int             nact;
    int unsigned    den;
    logic [RW-1:0]  kmod;
    logic [PSW-1:0] owner;
    logic [PSW-1:0] pick;
    logic           keep;

    always_comb begin
        slot_total = int'(nports) * (big ? BKT : 1);
        owner      = slot_owner(idx_q, big);
        nact       = $countones(snap_q);
        den        = (nact == 0) ? 1 : nact;
        kmod       = rnd % RW'(den);
        pick       = nth_active(snap_q, int'(kmod));
        keep       = (snap_q == port_mask) || (snap_q == '0) || snap_q[owner];
        wr.idx     = idx_q;
        wr.val     = keep ? (port_code_t'(owner) + port_code_t'(1))
                          : (port_code_t'(pick) + port_code_t'(1));
        wr_en      = (state == W_WALK);
        adv        = wr_en && !keep;
        commit     = (state == W_COMMIT);
        busy       = (state != W_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= W_IDLE;
            idx_q  <= '0;
            snap_q <= rst_mask;
        end else begin
            case (state)
                W_IDLE: begin
                    if (cur_status != snap_q) begin
                        snap_q <= cur_status;
                        idx_q  <= '0;
                        state  <= W_WALK;
                    end
                end
                W_WALK: begin
                    if (int'(idx_q) == slot_total - 1) state <= W_COMMIT;
                    else idx_q <= idx_q + 1'b1;
                end
                default: state <= W_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lag_slot_table.sv
module lag_slot_table
    import lag_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  port_code_t       rst_nports,
    input  logic             wr_en,
    input  slot_wr_t         wr,
    input  logic             commit,
    input  slot_idx_t        lk_idx,
    output port_code_t       lk_port,
    input  slot_idx_t        aff_idx,
    output port_code_t       aff_port,
    output logic             upd_valid,
    output logic [CW-1:0]    upd_count,
    output logic [SLOTS-1:0] upd_mask
);

    port_code_t       tbl [SLOTS];
    port_code_t       shd [SLOTS];
    logic [SLOTS-1:0] work_mask;
    logic [CW-1:0]    work_cnt;
    logic             diff;

    assign diff     = (wr.val != tbl[wr.idx]);
    assign lk_port  = tbl[lk_idx];
    assign aff_port = tbl[aff_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SLOTS; i++) begin
                tbl[i] <= native_entry(i, rst_nports);
                shd[i] <= native_entry(i, rst_nports);
            end
            work_mask <= '0;
            work_cnt  <= '0;
            upd_mask  <= '0;
            upd_count <= '0;
            upd_valid <= 1'b0;
        end else begin
            upd_valid <= 1'b0;
            if (wr_en) begin
                shd[wr.idx] <= wr.val;
                if (wr.idx == '0) begin
                    work_mask <= {{(SLOTS-1){1'b0}}, diff};
                    work_cnt  <= CW'(diff);
                end else begin
                    if (diff) work_mask[wr.idx] <= 1'b1;
                    work_cnt <= work_cnt + CW'(diff);
                end
            end
            if (commit) begin
                for (int i = 0; i < SLOTS; i++) tbl[i] <= shd[i];
                upd_mask  <= work_mask;
                upd_count <= work_cnt;
                upd_valid <= (work_cnt != '0);
            end
        end
    end

endmodule

// File: rtl/lag_bucket_remap.sv
module lag_bucket_remap
    import lag_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [PW-1:0]    cfg_nports,
    input  logic [MAXP-1:0]  tx_en,
    input  logic [MAXP-1:0]  link_up,
    input  logic [IW-1:0]    lk_idx,
    output logic [PW-1:0]    lk_port,
    input  logic [PSW-1:0]   aff_sel,
    output logic [PW-1:0]    aff_port,
    output logic             busy,
    output logic             upd_valid,
    output logic [CW-1:0]    upd_count,
    output logic [SLOTS-1:0] upd_mask
);

    port_code_t    cfg_n;
    port_code_t    nports_q;
    logic          big_q;
    pmask_t        port_mask;
    pmask_t        cur_status;
    slot_idx_t     aff_idx;
    logic [RW-1:0] rnd;
    logic          adv;
    logic          wr_en;
    logic          commit;
    slot_wr_t      wr;

    assign cfg_n      = clamp_ports(cfg_nports);
    assign port_mask  = mask_for(nports_q);
    assign cur_status = tx_en & link_up & port_mask;
    assign aff_idx    = big_q ? (slot_idx_t'(aff_sel) << BSH) : slot_idx_t'(aff_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            nports_q <= cfg_n;
            big_q    <= (buckets_for(cfg_n) > 1);
        end
    end

    lag_rand_lfsr u_rand (
        .clk (clk),
        .rst (rst),
        .adv (adv),
        .rnd (rnd)
    );

    lag_slot_walker u_walk (
        .clk        (clk),
        .rst        (rst),
        .rst_mask   (mask_for(cfg_n)),
        .cur_status (cur_status),
        .port_mask  (port_mask),
        .nports     (nports_q),
        .big        (big_q),
        .rnd        (rnd),
        .adv        (adv),
        .busy       (busy),
        .wr_en      (wr_en),
        .wr         (wr),
        .commit     (commit)
    );

    lag_slot_table u_tbl (
        .clk        (clk),
        .rst        (rst),
        .rst_nports (cfg_n),
        .wr_en      (wr_en),
        .wr         (wr),
        .commit     (commit),
        .lk_idx     (lk_idx),
        .lk_port    (lk_port),
        .aff_idx    (aff_idx),
        .aff_port   (aff_port),
        .upd_valid  (upd_valid),
        .upd_count  (upd_count),
        .upd_mask   (upd_mask)
    );

endmodule

// File: rtl/lag_bucket_remap_chk.sv
module lag_bucket_remap_chk
    import lag_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic [IW-1:0]    lk_idx,
    input logic [PW-1:0]    lk_port,
    input logic [PW-1:0]    aff_port,
    input logic             upd_valid,
    input logic [CW-1:0]    upd_count,
    input logic [SLOTS-1:0] upd_mask
);

    a_r6_table_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && $stable(lk_idx)) |-> $stable(lk_port));

    a_r6_walk_continues: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> busy);

    a_r7_mask_matches_count: assert property (@(posedge clk) disable iff (rst)
        upd_valid |-> (($countones(upd_mask) == int'(upd_count)) && (upd_count != '0)));

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        upd_valid |=> !upd_valid);

    a_r7_pulse_after_commit: assert property (@(posedge clk) disable iff (rst)
        upd_valid |-> !busy);

    a_r1_code_range: assert property (@(posedge clk) disable iff (rst)
        (int'(lk_port) <= MAXP) && (int'(aff_port) <= MAXP));

endmodule

bind lag_bucket_remap lag_bucket_remap_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .lk_idx    (lk_idx),
    .lk_port   (lk_port),
    .aff_port  (aff_port),
    .upd_valid (upd_valid),
    .upd_count (upd_count),
    .upd_mask  (upd_mask)
);

// File: tb/sim_lag_bucket_remap.sv
module sim_lag_bucket_remap;

    localparam int NP = 4;
    localparam int NS = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cfg_nports = 3'd4;
    logic [3:0]  tx_en = 4'hF;
    logic [3:0]  link_up = 4'hF;
    logic [5:0]  lk_idx = '0;
    logic [2:0]  lk_port;
    logic [1:0]  aff_sel = '0;
    logic [2:0]  aff_port;
    logic        busy;
    logic        upd_valid;
    logic [6:0]  upd_count;
    logic [63:0] upd_mask;

    always #2 clk = ~clk;

    lag_bucket_remap u0 (
        .clk        (clk),
        .rst        (rst),
        .cfg_nports (cfg_nports),
        .tx_en      (tx_en),
        .link_up    (link_up),
        .lk_idx     (lk_idx),
        .lk_port    (lk_port),
        .aff_sel    (aff_sel),
        .aff_port   (aff_port),
        .busy       (busy),
        .upd_valid  (upd_valid),
        .upd_count  (upd_count),
        .upd_mask   (upd_mask)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int pulses = 0;

    always @(posedge clk) if (!rst && upd_valid) pulses++;

    int          m_n;
    int          m_b;
    logic [2:0]  m_tbl [NS];
    logic [2:0]  nt    [NS];
    logic [31:0] m_rnd;
    logic [3:0]  m_applied;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] m_step(input logic [31:0] s);
        return (s >> 1) ^ (s[0] ? 32'h8020_0003 : 32'h0);
    endfunction

    function automatic logic [3:0] full_of(input int n);
        logic [3:0] m;
        for (int p = 0; p < NP; p++) m[p] = (p < n);
        return m;
    endfunction

    function automatic int m_nth(input logic [3:0] m, input int k);
        int seen = 0;
        for (int p = 0; p < NP; p++) begin
            if (m[p]) begin
                if (seen == k) return p;
                seen++;
            end
        end
        return 0;
    endfunction

    task automatic sweep(input bit after_reset);
        for (int i = 0; i < NS; i++) begin
            string tag;
            int    own;
            lk_idx = 6'(i);
            #0.5;
            own = i / m_b;
            if (after_reset || i >= m_n * m_b) tag = "R1 slot";
            else if (m_applied == full_of(m_n) || m_applied == 4'h0) tag = "R3 slot";
            else if (m_applied[own]) tag = "R5 slot";
            else tag = "R4 slot";
            check(lk_port == m_tbl[i], tag, lk_port, m_tbl[i]);
        end
        for (int a = 0; a < NP; a++) begin
            logic [2:0] e;
            aff_sel = 2'(a);
            #0.5;
            e = (a < m_n) ? m_tbl[a * m_b] : 3'd0;
            check(aff_port == e, "R8 affinity", aff_port, e);
        end
    endtask

    task automatic do_reset(input int cfg);
        @(negedge clk);
        rst = 1'b1;
        cfg_nports = 3'(cfg);
        tx_en = 4'hF;
        link_up = 4'hF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_n = (cfg == 0) ? 1 : (cfg > NP ? NP : cfg);
        m_b = (m_n > 2) ? 16 : 1;
        for (int i = 0; i < NS; i++) m_tbl[i] = (i < m_n * m_b) ? 3'(i / m_b + 1) : 3'd0;
        m_rnd = 32'h1;
        m_applied = full_of(m_n);
        @(negedge clk);
        check(busy == 1'b0, "R1 busy after reset", busy, 0);
        check(upd_valid == 1'b0 && upd_count == 7'd0, "R1 update outputs after reset", upd_count, 0);
        check(upd_mask == 64'h0, "R1 mask after reset", upd_mask, 0);
        sweep(1'b1);
    endtask

    task automatic apply(input logic [3:0] tx, input logic [3:0] lu);
        logic [3:0]  st;
        logic [63:0] emask;
        int          ecnt, probe, n, base, nact, total;
        bit          degen;
        @(negedge clk);
        tx_en = tx;
        link_up = lu;
        st = tx & lu & full_of(m_n);
        if (st == m_applied) begin
            repeat (3) begin
                @(posedge clk);
                #1;
                check(busy == 1'b0, "R9 no rebuild", busy, 0);
            end
            sweep(1'b0);
            return;
        end
        nact  = $countones(st);
        degen = (st == full_of(m_n)) || (st == 4'h0);
        emask = '0;
        ecnt  = 0;
        probe = -1;
        for (int p = 0; p < m_n; p++) begin
            for (int j = 0; j < m_b; j++) begin
                int idx = p * m_b + j;
                nt[idx] = 3'(p + 1);
                if (!degen && !st[p]) begin
                    nt[idx] = 3'(m_nth(st, int'(m_rnd % nact)) + 1);
                    m_rnd = m_step(m_rnd);
                end
            end
        end
        for (int i = m_n * m_b; i < NS; i++) nt[i] = 3'd0;
        for (int i = 0; i < NS; i++) begin
            if (nt[i] != m_tbl[i]) begin
                emask[i] = 1'b1;
                ecnt++;
                if (probe < 0) probe = i;
            end
        end
        if (probe < 0) probe = 0;
        lk_idx = 6'(probe);
        base   = pulses;
        total  = m_n * m_b;
        @(posedge clk);
        #1;
        n = 0;
        while (busy && n < 200) begin
            check(lk_port == m_tbl[probe], "R6 old table during walk", lk_port, m_tbl[probe]);
            n++;
            @(posedge clk);
            #1;
        end
        check(n == total + 1, "R6 busy length", n, total + 1);
        check(upd_valid == (ecnt > 0), "R7 valid pulse", upd_valid, ecnt > 0);
        check(int'(upd_count) == ecnt, "R7 changed count", upd_count, ecnt);
        check(upd_mask == emask, "R7 changed mask", upd_mask, emask);
        @(posedge clk);
        #1;
        check(pulses == base + ((ecnt > 0) ? 1 : 0), "R7 pulse count", pulses - base, ecnt > 0);
        check(upd_count == 7'(ecnt), "R7 count held", upd_count, ecnt);
        for (int i = 0; i < NS; i++) m_tbl[i] = nt[i];
        m_applied = st;
        sweep(1'b0);
    endtask

    task automatic random_round(input int iters);
        for (int k = 0; k < iters; k++) begin
            logic [3:0] tx, lu;
            tx = 4'($urandom) | 4'($urandom);
            lu = 4'($urandom) | 4'($urandom);
            apply(tx, lu);
        end
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        do_reset(4);
        apply(4'b1101, 4'b1111);
        apply(4'b1111, 4'b1111);
        apply(4'b0000, 4'b1111);
        apply(4'b1111, 4'b1010);
        apply(4'b1111, 4'b1011);
        @(negedge clk);
        aff_sel = 2'd2;
        #0.5;
        check(aff_port != 3'd3, "R2 link down disables port", aff_port, 3);
        apply(4'b1011, 4'b1111);
        apply(4'b1111, 4'b1111);
        random_round(20);
        do_reset(3);
        apply(4'b1011, 4'b1111);
        apply(4'b0000, 4'b0111);
        random_round(12);
        do_reset(2);
        apply(4'b0111, 4'b1111);
        apply(4'b1001, 4'b1111);
        apply(4'b0001, 4'b0111);
        random_round(12);
        do_reset(0);
        apply(4'b1110, 4'b1111);
        apply(4'b1111, 4'b1110);
        do_reset(7);
        random_round(8);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule